// File: doc/BRIEF.md
# Programmable Baud Tick Generator

This block divides its input clock by a programmable 16-bit divisor and produces a one-cycle enable pulse at sixteen times the serial bit rate. A receiver or transmitter elsewhere in the design uses that pulse as its oversampling strobe. The divisor is kept in two byte-wide latches, a low byte and a high byte. Firmware writes them through a small byte-wide register port.

The latches are reachable only while the divisor-access input is high. In that state, byte address 0 selects the low latch and byte address 1 selects the high latch. While the access input is low, those two addresses belong to the data and interrupt-enable registers outside this block. The generator ignores such writes and reads back zero.

Writing either latch reloads the internal down-counter at once with the complete new divisor, so a changed rate takes effect without waiting for the old period to finish. A divisor of zero is not a valid rate setting, and it parks the output low. Both latches clear on reset, so no ticks appear until firmware writes a divisor.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset both latches read back 0x00 and `tick` stays low until a divisor is written.
- R2: With `div_access`=1, a write to address 0 sets the low divisor byte and a write to address 1 sets the high byte (divisor = high*256 + low). A read of the same address returns the stored byte on `rdata` in the same cycle.
- R3: With `div_access`=0, writes to addresses 0 and 1 leave the divisor and the tick rate unchanged, and reads of those addresses return 0x00.
- R4: A write to either latch reloads the counter in the write cycle with the full new divisor D. The first tick is visible during the D-th clock cycle after the write edge, counting the cycle that follows the write edge as the first.
- R5: With a stable divisor D of 2 or more, `tick` is high for exactly one cycle in every D cycles.
- R6: With divisor 1, `tick` is high on every cycle.
- R7: With divisor 0, `tick` stays low.
- R8: Writes to addresses 2 and 3 have no effect on the divisor, and reads of those addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock being divided |
| rst_n | input | 1 | Active-low synchronous reset |
| div_access | input | 1 | 1 maps addresses 0/1 to the divisor latches |
| wr_en | input | 1 | Byte write strobe |
| addr | input | 2 | Register byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read-back of the addressed latch, 0 otherwise |
| tick | output | 1 | One-cycle 16x baud enable |

## Verification
The hardest situation to reach is a divisor write that lands partway through a running period, because only that write shows whether the counter restarts from the new full value. It is also the case that shows whether the counter instead finishes the old period, or loads a half-updated divisor. The random phase reaches it by issuing writes at arbitrary cycles while small divisors keep periods short, so many writes arrive with the counter partly down. A directed step also rewrites the low byte in the middle of a long period.

// File: rtl/baud_pkg.sv
package baud_pkg;
  // Value the down-counter takes after one clock with no register write.
  function automatic logic [15:0] step_count(input logic [15:0] cur, input logic [15:0] div);
    if (div == 16'd0)      return 16'd0;
    else if (cur <= 16'd1) return div;
    else                   return cur - 16'd1;
  endfunction

  // Pulse condition: counter at the last cycle of a valid period.
  function automatic logic pulse_now(input logic [15:0] cur, input logic [15:0] div);
    return (div != 16'd0) && (cur == 16'd1);
  endfunction
endpackage

// File: rtl/baud_div_latches.sv
module baud_div_latches #(
  parameter int DIV_W  = 16,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              div_access,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [DIV_W-1:0]  divisor,
  output logic [DIV_W-1:0]  div_next,
  output logic              load,
  output logic [BYTE_W-1:0] rdata
);
  localparam int NBYTES = DIV_W / BYTE_W;

  logic [NBYTES-1:0] hit;
  logic [NBYTES-1:0] sel;

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    logic [BYTE_W-1:0] q;
    assign sel[i] = div_access && (addr == ADDR_W'(i));
    assign hit[i] = sel[i] && wr_en;
    always_ff @(posedge clk) begin
      if (!rst_n)      q <= '0;
      else if (hit[i]) q <= wdata;
    end
    assign divisor[i*BYTE_W +: BYTE_W]  = q;
    assign div_next[i*BYTE_W +: BYTE_W] = hit[i] ? wdata : q;
  end

  assign load = |hit;

  always_comb begin
    rdata = '0;
    for (int j = 0; j < NBYTES; j++)
      if (sel[j]) rdata = divisor[j*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/baud_down_counter.sv
module baud_down_counter #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] div_next,
  input  logic [DIV_W-1:0] divisor,
  output logic [DIV_W-1:0] count,
  output logic             tick
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)                count <= '0;
    else if (load)             count <= div_next;
    else if (divisor == '0)    count <= '0;
    else if (count <= ONE)     count <= divisor;
    else                       count <= count - ONE;
  end

  assign tick = (divisor != '0) && (count == ONE);
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int DIV_W  = 16,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              div_access,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              tick
);
  logic [DIV_W-1:0] divisor;
  logic [DIV_W-1:0] div_next;
  logic [DIV_W-1:0] count;
  logic             load;

  baud_div_latches #(.DIV_W(DIV_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .div_access(div_access), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .divisor(divisor), .div_next(div_next),
    .load(load), .rdata(rdata)
  );

  baud_down_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .div_next(div_next),
    .divisor(divisor), .count(count), .tick(tick)
  );
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             div_access,
  input logic             wr_en,
  input logic             tick,
  input logic             load,
  input logic [DIV_W-1:0] divisor,
  input logic [DIV_W-1:0] count
);
  // R7
  zero_div_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor == '0) |-> !tick);
  // R6
  unit_div_every_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor == DIV_W'(1)) |-> tick);
  // R4
  reload_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == divisor));
  // R5
  period_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load) |=> (count == divisor));
  // R5
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && count > DIV_W'(1)) |=> (count == $past(count) - DIV_W'(1)));
  // R3
  blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!div_access && wr_en) |=> $stable(divisor));
endmodule

bind baud_tick_gen baud_tick_gen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .div_access(div_access), .wr_en(wr_en),
  .tick(tick), .load(load), .divisor(divisor), .count(count)
);

// File: tb/sim_baud_tick_gen.sv
module sim_baud_tick_gen;
  localparam int PERIOD = 10;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       div_access = 0;
  logic       wr_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic       tick;

  int tests = 0;
  int fails = 0;

  logic [7:0] m_lo = 0, m_hi = 0;
  int         m_k = 0;

  always #(PERIOD/2) clk = ~clk;

  baud_tick_gen u0 (.clk(clk), .rst_n(rst_n), .div_access(div_access), .wr_en(wr_en),
                    .addr(addr), .wdata(wdata), .rdata(rdata), .tick(tick));

  function automatic int mdiv(input logic [7:0] lo, input logic [7:0] hi);
    return int'(hi) * 256 + int'(lo);
  endfunction

  function automatic logic want_tick(input int k, input int d);
    return (d != 0) && (k == 1);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Called at a negedge: check tick, apply inputs for one clock, update model.
  task automatic cyc(input string req, input logic acc, input logic we,
                     input logic [1:0] a, input logic [7:0] d);
    int div;
    check(req, int'(tick), int'(want_tick(m_k, mdiv(m_lo, m_hi))));
    div_access = acc; wr_en = we; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0;
    if (we && acc && a == 2'd0) m_lo = d;
    if (we && acc && a == 2'd1) m_hi = d;
    div = mdiv(m_lo, m_hi);
    if (we && acc && a <= 2'd1) m_k = div;
    else if (div == 0)          m_k = 0;
    else if (m_k <= 1)          m_k = div;
    else                        m_k = m_k - 1;
  endtask

  task automatic idle(input string req, input int n);
    for (int i = 0; i < n; i++) cyc(req, 1'b1, 1'b0, 2'd0, 8'd0);
  endtask

  task automatic rd(input string req, input logic acc, input logic [1:0] a, input int exp);
    div_access = acc; addr = a;
    #1;
    check(req, int'(rdata), exp);
  endtask

  initial begin
    int unsigned r;
    int ticks;
    r = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd("R1", 1'b1, 2'd0, 0);
    rd("R1", 1'b1, 2'd1, 0);
    check("R1", int'(tick), 0);
    idle("R1", 20);
    // R6 divisor 1
    cyc("R2", 1'b1, 1'b1, 2'd0, 8'd1);
    rd("R2", 1'b1, 2'd0, 1);
    idle("R6", 10);
    // R5 divisor 5: count ticks over 20 cycles
    cyc("R4", 1'b1, 1'b1, 2'd0, 8'd5);
    ticks = 0;
    for (int i = 0; i < 20; i++) begin
      if (tick) ticks++;
      cyc("R5", 1'b1, 1'b0, 2'd0, 8'd0);
    end
    check("R5", ticks, 4);
    // R4 mid-period rewrite with a longer divisor
    cyc("R4", 1'b1, 1'b1, 2'd0, 8'd40);
    idle("R4", 17);
    cyc("R4", 1'b1, 1'b1, 2'd0, 8'd9);
    ticks = 0;
    for (int i = 0; i < 8; i++) begin
      if (tick) ticks++;
      cyc("R4", 1'b1, 1'b0, 2'd0, 8'd0);
    end
    check("R4", ticks, 0);
    check("R4", int'(tick), 1);
    idle("R4", 12);
    // R3 writes with access low are ignored
    cyc("R3", 1'b0, 1'b1, 2'd0, 8'd2);
    cyc("R3", 1'b0, 1'b1, 2'd1, 8'd7);
    rd("R3", 1'b0, 2'd0, 0);
    rd("R3", 1'b0, 2'd1, 0);
    rd("R3", 1'b1, 2'd0, 9);
    rd("R3", 1'b1, 2'd1, 0);
    idle("R3", 30);
    // R8 addresses 2 and 3
    cyc("R8", 1'b1, 1'b1, 2'd2, 8'd3);
    cyc("R8", 1'b1, 1'b1, 2'd3, 8'd3);
    rd("R8", 1'b1, 2'd2, 0);
    rd("R8", 1'b1, 2'd3, 0);
    idle("R8", 30);
    // R2 high byte: divisor 256
    cyc("R2", 1'b1, 1'b1, 2'd1, 8'd1);
    cyc("R2", 1'b1, 1'b1, 2'd0, 8'd0);
    rd("R2", 1'b1, 2'd1, 1);
    ticks = 0;
    for (int i = 0; i < 600; i++) begin
      if (tick) ticks++;
      cyc("R2", 1'b1, 1'b0, 2'd0, 8'd0);
    end
    check("R2", ticks, 2);
    // R7 divisor 0
    cyc("R7", 1'b1, 1'b1, 2'd1, 8'd0);
    ticks = 0;
    for (int i = 0; i < 50; i++) begin
      if (tick) ticks++;
      cyc("R7", 1'b1, 1'b0, 2'd0, 8'd0);
    end
    check("R7", ticks, 0);
    // Random mix
    for (int i = 0; i < 4000; i++) begin
      r = $urandom;
      if (r[3:0] == 4'd0) begin
        logic [7:0] d;
        d = (r[4] && r[5]) ? 8'(r[15:8]) : 8'(r[11:8] % 12);
        cyc("R4", r[16] | r[17], 1'b1, 2'(r[19:18] & {r[20], 1'b1}), d);
      end else begin
        cyc("R5", 1'b1, 1'b0, 2'd0, 8'd0);
      end
      if (r[24:21] == 4'd3) begin
        rd("R2", 1'b1, 2'd0, int'(m_lo));
        rd("R2", 1'b1, 2'd1, int'(m_hi));
        @(negedge clk);
        if (m_k > 0) begin
          if (m_k <= 1) m_k = mdiv(m_lo, m_hi); else m_k = m_k - 1;
        end
      end
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule